// File: doc/BRIEF.md
# Multi-Chip Status Merge Sequencer

This block sits beside a group of cascaded array chips. When the chips reach a global evaluation step, each one computes a 16-bit status word and stops until it is released. Only chip 0 tells the sequencer that the step has been reached. The sequencer first reads a command word from chip 0. This word holds a register address and an operation code. It then reads the status word of every chip in turn over one shared 16-bit bus, picking the chip with a one-hot select.

The sequencer merges the words. It adds the population-count fields and ANDs the "all ones" and "all zeros" flags. It then applies the operation to one entry of a 256-entry, 16-bit register file. It sends a merged result back to the chips together with a one-cycle release pulse. One operation also raises an interrupt and keeps the chips stopped until the host acknowledges it, so software can combine values in its own way. The host can read any entry through a registered read port at any time.

Top module: `statacc_top`

## Requirements
- R1: After reset, every register-file entry reads 0, and `bus_sel_o`, `bus_cmd_o`, `resume_o`, `irq_o` and `bcast_o` are 0.
- R2: When idle with `eval_req_i` high, in the next cycle the block selects chip 0 (`bus_sel_o` = 1) with `bus_cmd_o` = 1. It captures the register address from bus bits [7:0] and the operation code from bus bits [10:8].
- R3: After the command cycle, chips 0 to N-1 are selected one per cycle in rising index order, with `bus_cmd_o` = 0. Outside a transaction `bus_sel_o` is 0, and it is never more than one-hot.
- R4: Status word layout: bit 15 = all-ones flag, bit 14 = all-zeros flag, bits [13:0] = count. The merged word has each flag as the AND over all chips, and its count is the sum of the counts, saturating at 0x3FFF.
- R5: `resume_o` is a one-cycle pulse in the cycle after the last chip read (or after the acknowledge, see R11). `bcast_o` is valid with that pulse and holds until the next transaction updates it.
- R6: Operation 0 (clear) sets the addressed entry to 0. `bcast_o` is the merged word.
- R7: Operation 1 (accumulate) adds the merged count to the entry, saturating at 0xFFFF. `bcast_o` is the merged word.
- R8: Operation 2 (halve) shifts the entry right by one bit. `bcast_o` is the merged word.
- R9: Operations 3, 6 and 7 (read) leave every entry unchanged. `bcast_o` is the value of the addressed entry.
- R10: Operation 4 (write) stores the merged word in the entry. `bcast_o` is the merged word.
- R11: Operation 5 stores as in R10 and raises `irq_o` in the cycle after the last read. `irq_o` stays high, and `resume_o` stays low, until `irq_ack_i` is sampled high. `resume_o` then pulses in the next cycle.
- R12: `host_rdata_o` shows the entry at the `host_addr_i` sampled on the previous clock edge. The store of a transaction is visible in the cycle that carries `resume_o` or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_req_i | input | 1 | Evaluation request from chip 0 (level) |
| bus_sel_o | output | NUM_CHIPS | One-hot chip select on the shared status bus |
| bus_cmd_o | output | 1 | Selected chip drives its command word instead of its status |
| stat_bus_i | input | 16 | Shared status/command bus |
| resume_o | output | 1 | Release pulse to all chips |
| bcast_o | output | 16 | Result sent back to the chips |
| irq_o | output | 1 | Host interrupt for software-combined write |
| irq_ack_i | input | 1 | Host acknowledge of the interrupt |
| host_addr_i | input | ADDR_W | Host read address |
| host_rdata_o | output | 16 | Host read data (one-cycle latency) |

## Verification
The assertions assume that chip 0 drops `eval_req_i` in the cycle that carries `resume_o`, so no second request arrives before the block is idle again. They also assume that `irq_ack_i` is only raised while `irq_o` is high. The bench follows both rules: it releases the request when it sees the release pulse, and it pulses the acknowledge only during an interrupt wait. The chips' bus responses come from a bench model keyed on the select and command lines, so bus contention cannot occur.

// File: rtl/statacc_pkg.sv
package statacc_pkg;

    localparam int STAT_W   = 16;
    localparam int CNT_W    = 14;
    localparam int ALL1_BIT = 15;
    localparam int ALL0_BIT = 14;
    localparam int OPF_LSB  = 8;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_CLEAR     = 3'd0,
        OP_ACCUM     = 3'd1,
        OP_HALVE     = 3'd2,
        OP_READ      = 3'd3,
        OP_WRITE     = 3'd4,
        OP_WRITE_IRQ = 3'd5,
        OP_RSV6      = 3'd6,
        OP_RSV7      = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CMD  = 3'd1,
        S_POLL = 3'd2,
        S_RES  = 3'd3,
        S_IRQ  = 3'd4
    } seq_e;

    typedef struct packed {
        logic             all1;
        logic             all0;
        logic [CNT_W-1:0] cnt;
    } merge_t;

endpackage

// File: rtl/stat_merge.sv
module stat_merge
    import statacc_pkg::*;
(
    input  merge_t            acc_i,
    input  logic [STAT_W-1:0] word_i,
    output merge_t            acc_o
);
    logic [CNT_W:0] sum;

    always_comb begin
        sum        = {1'b0, acc_i.cnt} + {1'b0, word_i[CNT_W-1:0]};
        acc_o.all1 = acc_i.all1 & word_i[ALL1_BIT];
        acc_o.all0 = acc_i.all0 & word_i[ALL0_BIT];
        acc_o.cnt  = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
endmodule

// File: rtl/reg_update.sv
module reg_update
    import statacc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] old_i,
    input  merge_t            comb_i,
    output logic [DATA_W-1:0] new_o,
    output logic [DATA_W-1:0] bcast_o,
    output logic              we_o,
    output logic              irq_o
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] merged_word;
    logic [SUM_W-1:0]  acc_sum;

    always_comb begin
        merged_word = DATA_W'(comb_i);
        acc_sum     = {1'b0, old_i} + SUM_W'(comb_i.cnt);
        new_o       = old_i;
        bcast_o     = merged_word;
        we_o        = 1'b1;
        irq_o       = 1'b0;
        case (op_i)
            OP_CLEAR: new_o = '0;
            OP_ACCUM: new_o = acc_sum[DATA_W] ? {DATA_W{1'b1}} : acc_sum[DATA_W-1:0];
            OP_HALVE: new_o = old_i >> 1;
            OP_WRITE: new_o = merged_word;
            OP_WRITE_IRQ: begin
                new_o = merged_word;
                irq_o = 1'b1;
            end
            default: begin
                we_o    = 1'b0;
                bcast_o = old_i;
            end
        endcase
    end
endmodule

// File: rtl/status_regfile.sv
module status_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] seq_addr_i,
    output logic [DATA_W-1:0] seq_data_o,
    input  logic [ADDR_W-1:0] host_addr_i,
    output logic [DATA_W-1:0] host_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] hrd_q;

    assign seq_data_o  = mem_q[seq_addr_i];
    assign host_data_o = hrd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            hrd_q <= '0;
        end else begin
            if (we_i) mem_q[waddr_i] <= wdata_i;
            hrd_q <= mem_q[host_addr_i];
        end
    end
endmodule

// File: rtl/statacc_top.sv
module statacc_top
    import statacc_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval_req_i,
    output logic [NUM_CHIPS-1:0] bus_sel_o,
    output logic                 bus_cmd_o,
    input  logic [STAT_W-1:0]    stat_bus_i,
    output logic                 resume_o,
    output logic [STAT_W-1:0]    bcast_o,
    output logic                 irq_o,
    input  logic                 irq_ack_i,
    input  logic [ADDR_W-1:0]    host_addr_i,
    output logic [STAT_W-1:0]    host_rdata_o
);
    localparam int IDX_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHIPS - 1);

    typedef struct packed {
        seq_e              st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        op_e               op;
        merge_t            acc;
        logic [STAT_W-1:0] bcast;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    merge_t            merged;
    logic [STAT_W-1:0] rf_old, upd_new, upd_bcast;
    logic              upd_we, upd_irq, rf_we;

    stat_merge u_merge (
        .acc_i  (ctl_q.acc),
        .word_i (stat_bus_i),
        .acc_o  (merged)
    );

    reg_update #(.DATA_W(STAT_W)) u_update (
        .op_i    (ctl_q.op),
        .old_i   (rf_old),
        .comb_i  (merged),
        .new_o   (upd_new),
        .bcast_o (upd_bcast),
        .we_o    (upd_we),
        .irq_o   (upd_irq)
    );

    status_regfile #(.ADDR_W(ADDR_W), .DATA_W(STAT_W)) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (rf_we),
        .waddr_i     (ctl_q.addr),
        .wdata_i     (upd_new),
        .seq_addr_i  (ctl_q.addr),
        .seq_data_o  (rf_old),
        .host_addr_i (host_addr_i),
        .host_data_o (host_rdata_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        rf_we = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (eval_req_i) ctl_d.st = S_CMD;
            end
            S_CMD: begin
                ctl_d.addr = stat_bus_i[ADDR_W-1:0];
                ctl_d.op   = op_e'(stat_bus_i[OPF_LSB +: OP_W]);
                ctl_d.acc  = '{all1: 1'b1, all0: 1'b1, cnt: '0};
                ctl_d.idx  = '0;
                ctl_d.st   = S_POLL;
            end
            S_POLL: begin
                ctl_d.acc = merged;
                if (ctl_q.idx == LAST_IDX) begin
                    rf_we       = upd_we;
                    ctl_d.bcast = upd_bcast;
                    ctl_d.st    = upd_irq ? S_IRQ : S_RES;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            S_IRQ: begin
                if (irq_ack_i) ctl_d.st = S_RES;
            end
            S_RES: begin
                ctl_d.st = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_sel
        if (g == 0) begin : g_first
            assign bus_sel_o[g] = (ctl_q.st == S_CMD) ||
                                  (ctl_q.st == S_POLL && ctl_q.idx == IDX_W'(g));
        end else begin : g_rest
            assign bus_sel_o[g] = (ctl_q.st == S_POLL && ctl_q.idx == IDX_W'(g));
        end
    end

    assign bus_cmd_o = (ctl_q.st == S_CMD);
    assign resume_o  = (ctl_q.st == S_RES);
    assign irq_o     = (ctl_q.st == S_IRQ);
    assign bcast_o   = ctl_q.bcast;

endmodule

// File: rtl/statacc_chk.sv
module statacc_chk #(
    parameter int NUM_CHIPS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 eval_req_i,
    input logic [NUM_CHIPS-1:0] bus_sel_o,
    input logic                 bus_cmd_o,
    input logic                 resume_o,
    input logic                 irq_o,
    input logic                 irq_ack_i
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel_o)); // R3

    AST_CMD_FROM_CHIP0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_o |-> (bus_sel_o == NUM_CHIPS'(1))); // R2

    AST_CMD_THEN_POLL0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_o |=> (bus_sel_o[0] && !bus_cmd_o)); // R3

    AST_LAST_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_o[NUM_CHIPS-1] && !bus_cmd_o) |=> (resume_o || irq_o)); // R5

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o); // R5

    AST_RESUME_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o || irq_o) |-> (bus_sel_o == '0)); // R3

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack_i) |=> (irq_o && !resume_o)); // R11

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_ack_i) |=> (resume_o && !irq_o)); // R11

    AST_IDLE_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req_i && !resume_o && !irq_o && bus_sel_o == '0) |=> bus_cmd_o); // R2
endmodule

bind statacc_top statacc_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_req_i (eval_req_i),
    .bus_sel_o  (bus_sel_o),
    .bus_cmd_o  (bus_cmd_o),
    .resume_o   (resume_o),
    .irq_o      (irq_o),
    .irq_ack_i  (irq_ack_i)
);

// File: tb/statacc_top_test.sv
module statacc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           eval_req = 1'b0;
    logic [NCH-1:0] bus_sel;
    logic           bus_cmd;
    logic [15:0]    stat_bus;
    logic           resume;
    logic [15:0]    bcast;
    logic           irq;
    logic           irq_ack = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [15:0]    host_rdata;

    logic [15:0] cmd_word = '0;
    logic [15:0] chip_w [NCH];
    int          model_rf [256];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          in_txn = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    statacc_top #(.NUM_CHIPS(NCH), .ADDR_W(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval_req_i   (eval_req),
        .bus_sel_o    (bus_sel),
        .bus_cmd_o    (bus_cmd),
        .stat_bus_i   (stat_bus),
        .resume_o     (resume),
        .bcast_o      (bcast),
        .irq_o        (irq),
        .irq_ack_i    (irq_ack),
        .host_addr_i  (host_addr),
        .host_rdata_o (host_rdata)
    );

    // Chip models answering on the shared bus
    always_comb begin
        stat_bus = '0;
        for (int k = 0; k < NCH; k++)
            if (bus_sel[k]) stat_bus = bus_cmd ? cmd_word : chip_w[k];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every clock: outside a transaction the chip-facing outputs stay quiet
    always @(posedge clk) begin
        #1;
        cycles++;
        if (rst_n && !in_txn) begin
            check(bus_sel == '0 && !bus_cmd, "R3 idle select", int'(bus_sel), 0);
            check(!resume && !irq, "R5 idle release", int'({resume, irq}), 0);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] merge_words();
        int  sum = 0;
        bit  a1 = 1'b1, a0 = 1'b1;
        for (int k = 0; k < NCH; k++) begin
            sum += int'(chip_w[k][13:0]);
            a1 &= chip_w[k][15];
            a0 &= chip_w[k][14];
        end
        if (sum > 16'h3FFF) sum = 16'h3FFF;
        return {a1, a0, 14'(sum)};
    endfunction

    task automatic run_eval(input logic [7:0] a, input logic [2:0] op,
                            input logic [15:0] w0, input logic [15:0] w1,
                            input logic [15:0] w2, input logic [15:0] w3,
                            input string tag);
        logic [15:0] m, expb;
        int          oldv, newv;
        @(negedge clk);
        in_txn = 1'b1;
        cmd_word = {5'b0, op, a};
        chip_w[0] = w0; chip_w[1] = w1; chip_w[2] = w2; chip_w[3] = w3;
        eval_req = 1'b1;
        @(negedge clk);
        check(bus_sel == 4'b0001 && bus_cmd, "R2 command read", int'({bus_cmd, bus_sel}), 5'h11);
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            check(bus_sel == NCH'(1 << k) && !bus_cmd && !resume, "R3 poll order",
                  int'({bus_cmd, bus_sel}), 1 << k);
        end
        m = merge_words();
        oldv = model_rf[a];
        newv = oldv;
        expb = m;
        case (op)
            3'd0: newv = 0;
            3'd1: begin newv = oldv + int'(m[13:0]); if (newv > 16'hFFFF) newv = 16'hFFFF; end
            3'd2: newv = oldv >> 1;
            3'd4, 3'd5: newv = int'(m);
            default: expb = 16'(oldv);
        endcase
        model_rf[a] = newv;
        @(negedge clk);
        if (op == 3'd5) begin
            check(irq && !resume, "R11 interrupt raised", int'({irq, resume}), 2);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check(irq && !resume, "R11 interrupt held", int'({irq, resume}), 2);
            end
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            check(!irq, "R11 interrupt cleared", int'(irq), 0);
        end
        check(resume, "R5 release pulse", int'(resume), 1);
        check(bcast == expb, tag, int'(bcast), int'(expb));
        eval_req = 1'b0;
        @(negedge clk);
        check(!resume, "R5 single pulse", int'(resume), 0);
        check(bcast == expb, "R5 broadcast held", int'(bcast), int'(expb));
        in_txn = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input string tag);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        check(host_rdata == 16'(model_rf[a]), tag, int'(host_rdata), model_rf[a]);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model_rf[i] = 0;
        for (int k = 0; k < NCH; k++) chip_w[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_sel == '0 && !bus_cmd && !resume && !irq && bcast == '0, "R1 reset outputs",
              int'({bus_sel, bus_cmd, resume, irq}), 0);
        host_read(8'h05, "R1 reset entry 5");
        host_read(8'hFF, "R1 reset entry FF");

        // Plain write with mixed flags
        run_eval(8'h05, 3'd4, 16'h0003, 16'h0005, 16'h4000, 16'h0001, "R10 write broadcast");
        host_read(8'h05, "R10 write stored");
        // Accumulate: only count adds; all-ones flags AND to 1
        run_eval(8'h05, 3'd1, 16'h8020, 16'h8020, 16'h8020, 16'h8020, "R4 merged flags");
        host_read(8'h05, "R7 accumulate");
        // Count saturation of the merge
        run_eval(8'hFF, 3'd4, 16'hBFFF, 16'hBFFF, 16'hBFFF, 16'hBFFF, "R4 count saturation");
        host_read(8'hFF, "R10 write saturated word");
        run_eval(8'hFF, 3'd1, 16'h3FFF, 16'h3FFF, 16'h3FFF, 16'h3FFF, "R7 accumulate broadcast");
        host_read(8'hFF, "R7 accumulate near top");
        run_eval(8'hFF, 3'd1, 16'h3FFF, 16'h3FFF, 16'h3FFF, 16'h3FFF, "R7 accumulate broadcast");
        host_read(8'hFF, "R7 accumulate saturates");
        run_eval(8'hFF, 3'd2, 16'h0001, 16'h0002, 16'h0003, 16'h0004, "R8 halve broadcast");
        host_read(8'hFF, "R8 halve");
        // Read operations return the entry and change nothing
        run_eval(8'h05, 3'd3, 16'h1111, 16'h2222, 16'h0333, 16'h0044, "R9 read broadcast");
        host_read(8'h05, "R9 read unchanged");
        run_eval(8'h05, 3'd7, 16'h0100, 16'h0100, 16'h0100, 16'h0100, "R9 code 7 broadcast");
        host_read(8'h05, "R9 code 7 unchanged");
        host_read(8'hFF, "R9 other entry unchanged");
        // Clear, with all-zeros flags set
        run_eval(8'h05, 3'd0, 16'h4000, 16'h4000, 16'h4000, 16'h4000, "R6 clear broadcast");
        host_read(8'h05, "R6 clear");
        // Interrupting write
        run_eval(8'h10, 3'd5, 16'h0007, 16'h8001, 16'h0002, 16'h0000, "R11 broadcast");
        host_read(8'h10, "R11 write stored");
        host_read(8'hFF, "R12 host port");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule